// File: doc/BRIEF.md
# Step Attenuator Control Latch

This block is the digital control front end of a six-stage step attenuator that covers 0 to 31.5 dB in 0.5 dB increments. It receives a six-bit parallel control word and a latch-enable line, and it drives a registered six-bit attenuation word to the switch stages. A second output gives the same setting as an unsigned count of half-decibel units.

Latch-enable selects one of two modes. While it is high, the output follows the parallel inputs. While it is low, the output holds its value, and a high pulse on it loads a new word. When the power-on reset is released, the block also sets a known starting state. If latch-enable is low at that moment, two select pins choose one of four preset words. If it is high, the parallel inputs supply the first word. An external pull-up holds latch-enable high when nothing drives it, so by default the block starts in direct mode.

Every input is sampled on the system clock. A control value reaches the output word two clock edges after it is sampled. The first edge captures the value into a sample stage, and the second moves it into the word, provided latch-enable was high at the first edge.

Top module: `att_ctl_latch`

## Requirements
- R1: While `por_ni` is low, `atten_o` is 0.
- R2: At the first clock edge after `por_ni` rises, if `latch_en_i` is low, `atten_o` takes the preset chosen by `psel_i`: 00 gives 0, 01 gives 16 (8 dB), 10 gives 32 (16 dB) and 11 gives 62 (31 dB).
- R3: At the first clock edge after `por_ni` rises, if `latch_en_i` is high, `atten_o` takes `ctl_i` and `psel_i` has no effect.
- R4: After the first edge, if `latch_en_i` was high at clock edge n-1, `atten_o` after edge n equals the `ctl_i` sampled at edge n-1.
- R5: If `latch_en_i` was low at edge n-1, `atten_o` keeps its value through edge n, whatever `ctl_i` does.
- R6: When latch-enable goes high for one or more cycles and then returns low, the word after the pulse is the `ctl_i` sampled at the last edge where latch-enable was high.
- R7: After the first edge, changes on `psel_i` have no effect on `atten_o`.
- R8: `atten_half_o` is `atten_o` zero-extended to 7 bits, which gives the attenuation in 0.5 dB units. For example, bit 5 alone (16 dB) reads 32.
- R9: Bit k of the control word weighs 0.5·2^k dB. Bit 0 is 0.5 dB, bit 5 is 16 dB, and all ones (63) is 31.5 dB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous assert |
| ctl_i | input | 6 | Parallel attenuation control word, bit 5 = 16 dB |
| latch_en_i | input | 1 | High: output follows inputs; falling edge: load word |
| psel_i | input | 2 | Power-up preset select, sampled only at the first edge |
| atten_o | output | 6 | Registered attenuation word to the switch stages |
| atten_half_o | output | 7 | Attenuation in 0.5 dB units |

## Verification
Each power-up preset appears only on the single edge where reset is released, so the bench has to leave reset four times with latch-enable held low, once for each select value. After each release it moves the select pins to a different value to show they no longer matter. A fifth release with latch-enable high covers the direct start. The bench drives latch pulses that last several cycles, with the input changing inside the pulse, so the word must come from the last high sample and not from the first. A behavioural model updated at every edge compares the outputs on every cycle.

// File: rtl/att_pkg.sv
package att_pkg;
    localparam int ATT_WORD_W = 6;
    localparam int ATT_SEL_W  = 2;

    typedef enum logic {
        PH_BOOT = 1'b0,
        PH_RUN  = 1'b1
    } att_phase_e;
endpackage

// File: rtl/att_preset_table.sv
module att_preset_table #(
    parameter int W     = 6,
    parameter int SEL_W = 2,
    localparam int NSEL = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [W-1:0]     code_o
);
    logic [W-1:0] tbl [NSEL];

    // entry 0 is the reference, the last entry is full scale less one step,
    // the ones between are single power-of-two weights counting up from the top
    for (genvar k = 0; k < NSEL; k++) begin : g_ent
        if (k == 0) begin : g_ref
            assign tbl[k] = '0;
        end else if (k == NSEL - 1) begin : g_top
            assign tbl[k] = {{(W-1){1'b1}}, 1'b0};
        end else begin : g_pow
            assign tbl[k] = W'(1) << (W - SEL_W + k - 1);
        end
    end

    assign code_o = tbl[sel_i];
endmodule

// File: rtl/att_unit_map.sv
module att_unit_map #(
    parameter int W = 6,
    localparam int OUT_W = W + 1
) (
    input  logic [W-1:0]     word_i,
    output logic [OUT_W-1:0] half_o
);
    // one LSB of the word is one half-decibel unit
    assign half_o = OUT_W'(word_i);
endmodule

// File: rtl/att_ctl_latch.sv
module att_ctl_latch
    import att_pkg::*;
#(
    parameter int W     = ATT_WORD_W,
    parameter int SEL_W = ATT_SEL_W,
    localparam int UNIT_W = W + 1
) (
    input  logic              clk_i,
    input  logic              por_ni,
    input  logic [W-1:0]      ctl_i,
    input  logic              latch_en_i,
    input  logic [SEL_W-1:0]  psel_i,
    output logic [W-1:0]      atten_o,
    output logic [UNIT_W-1:0] atten_half_o
);
    typedef struct packed {
        att_phase_e   phase;
        logic         le;
        logic [W-1:0] smp;
        logic [W-1:0] word;
    } st_t;

    st_t          st_d, st_q;
    logic [W-1:0] preset_w;

    att_preset_table #(.W(W), .SEL_W(SEL_W)) u_preset (
        .sel_i  (psel_i),
        .code_o (preset_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.le    = latch_en_i;
        st_d.smp   = ctl_i;
        if (st_q.phase == PH_BOOT) begin
            st_d.phase = PH_RUN;
            st_d.word  = latch_en_i ? ctl_i : preset_w;
        end else if (st_q.le) begin
            // transparent while high; on the falling edge this loads the
            // sample taken on the last high cycle, then the word holds
            st_d.word = st_q.smp;
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            st_q <= '{phase: PH_BOOT, le: 1'b0, smp: '0, word: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign atten_o = st_q.word;

    att_unit_map #(.W(W)) u_units (
        .word_i (st_q.word),
        .half_o (atten_half_o)
    );
endmodule

// File: rtl/att_ctl_latch_chk.sv
module att_ctl_latch_chk #(
    parameter int W     = 6,
    parameter int SEL_W = 2
) (
    input logic             clk_i,
    input logic             por_ni,
    input logic [W-1:0]     ctl_i,
    input logic             latch_en_i,
    input logic [SEL_W-1:0] psel_i,
    input logic [W-1:0]     atten_o,
    input logic [W:0]       atten_half_o
);
    logic [1:0] live_q;

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) live_q <= 2'd0;
        else if (live_q != 2'd3) live_q <= live_q + 2'd1;
    end

    function automatic logic [W-1:0] exp_preset(input logic [SEL_W-1:0] s);
        case (s)
            2'd0:    return W'(0);
            2'd1:    return W'(16);
            2'd2:    return W'(32);
            default: return W'(62);
        endcase
    endfunction

    a_r2_boot_preset: assert property (@(posedge clk_i) disable iff (!por_ni)
        (live_q == 2'd1 && !$past(latch_en_i)) |-> atten_o == exp_preset($past(psel_i)));

    a_r3_boot_direct: assert property (@(posedge clk_i) disable iff (!por_ni)
        (live_q == 2'd1 && $past(latch_en_i)) |-> atten_o == $past(ctl_i));

    a_r4_follow: assert property (@(posedge clk_i) disable iff (!por_ni)
        (live_q >= 2'd2 && $past(latch_en_i, 2)) |-> atten_o == $past(ctl_i, 2));

    a_r5_hold: assert property (@(posedge clk_i) disable iff (!por_ni)
        (live_q >= 2'd2 && !$past(latch_en_i, 2)) |-> $stable(atten_o));

    a_r8_units: assert property (@(posedge clk_i) disable iff (!por_ni)
        (atten_half_o[W] == 1'b0) && (atten_half_o[W-1:0] == atten_o));
endmodule

bind att_ctl_latch att_ctl_latch_chk #(.W(W), .SEL_W(SEL_W)) u_chk (
    .clk_i        (clk_i),
    .por_ni       (por_ni),
    .ctl_i        (ctl_i),
    .latch_en_i   (latch_en_i),
    .psel_i       (psel_i),
    .atten_o      (atten_o),
    .atten_half_o (atten_half_o)
);

// File: tb/tb_att_ctl_latch.sv
module tb_att_ctl_latch;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic [5:0] ctl = '0;
    logic       le = 1'b0;
    logic [1:0] sel = 2'd0;
    logic [5:0] atten;
    logic [6:0] half;

    int n_run = 0;
    int n_fail = 0;
    string tag = "R1";

    att_ctl_latch dut (
        .clk_i(clk), .por_ni(por_n), .ctl_i(ctl), .latch_en_i(le),
        .psel_i(sel), .atten_o(atten), .atten_half_o(half)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int preset_ref(input int s);
        case (s)
            0: return 0;
            1: return 16;
            2: return 32;
            default: return 62;
        endcase
    endfunction

    // behavioural reference model
    int  m_exp = 0;
    bit  m_boot = 1;
    bit  m_ple = 0;
    int  m_pctl = 0;
    always @(posedge clk) begin
        if (!por_n) begin
            m_exp = 0; m_boot = 1; m_ple = 0; m_pctl = 0;
        end else if (m_boot) begin
            m_exp = le ? int'(ctl) : preset_ref(int'(sel));
            m_boot = 0; m_ple = le; m_pctl = int'(ctl);
        end else begin
            if (m_ple) m_exp = m_pctl;
            m_ple = le; m_pctl = int'(ctl);
        end
    end

    task automatic chk(input string t, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        chk(tag, int'(atten), m_exp);
        chk("R8", int'(half), int'(atten));
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        int held;
        tag = "R1"; sel = 2'd1; ctl = 6'h2A;
        tick(3);
        chk("R1", int'(atten), 0);

        for (int k = 0; k < 4; k++) begin
            tag = "R2"; por_n = 1'b0; le = 1'b0; sel = 2'(k); ctl = 6'h3F;
            tick(2);
            chk("R1", int'(atten), 0);
            por_n = 1'b1;
            tick(1);
            chk("R2", int'(atten), preset_ref(k));
            tag = "R7"; sel = ~2'(k); ctl = 6'h11;
            tick(3);
            chk("R7", int'(atten), preset_ref(k));
        end

        tag = "R3"; por_n = 1'b0; le = 1'b1; sel = 2'd3; ctl = 6'h15;
        tick(2);
        por_n = 1'b1;
        tick(1);
        chk("R3", int'(atten), 'h15);

        tag = "R4";
        for (int i = 0; i < 10; i++) begin
            ctl = 6'((i * 7 + 3) & 63);
            tick(1);
        end
        tick(1);
        chk("R4", int'(atten), (9 * 7 + 3) & 63);
        held = (9 * 7 + 3) & 63;

        tag = "R5"; le = 1'b0;
        tick(1);
        for (int i = 0; i < 5; i++) begin
            ctl = 6'(i * 13);
            tick(1);
        end
        chk("R5", int'(atten), held);

        tag = "R6"; le = 1'b1; ctl = 6'h0B;
        tick(1);
        le = 1'b0; ctl = 6'h30;
        tick(1);
        chk("R6", int'(atten), 'h0B);
        tick(2);
        chk("R6", int'(atten), 'h0B);
        le = 1'b1; ctl = 6'h01;
        tick(1);
        ctl = 6'h22;
        tick(1);
        ctl = 6'h2C;
        tick(1);
        le = 1'b0; ctl = 6'h00;
        tick(1);
        chk("R6", int'(atten), 'h2C);
        tick(2);
        chk("R6", int'(atten), 'h2C);

        tag = "R9"; le = 1'b1; ctl = 6'h3F;
        tick(2);
        chk("R9", int'(atten), 63);
        chk("R8", int'(half), 63);
        ctl = 6'h20;
        tick(2);
        chk("R9", int'(atten), 32);
        chk("R8", int'(half), 32);
        ctl = 6'h01;
        tick(2);
        chk("R8", int'(half), 1);

        tick(2);
        finish_run();
    end
endmodule